// File: doc/BRIEF.md
# Multi-Window DMA Address Translator

This block turns a 64-bit address arriving from the I/O side of a bridge into a system memory address. The address is sorted into one of five windows: a 64-bit pass-through window, a 32-bit direct window relocated by a per-port base register, and three table-driven windows. The table-driven windows are a 32-bit window with programmable pages, a 40-bit window with 64 MB pages, and a 40-bit window with 16 GB super pages. A registered response carries the system address, the barrier flag where the window defines one, and an error flag.

The table-driven windows read translation entries. Each entry is a page-aligned system address with bit 63 as its valid flag. The super-page window and the 32-bit window share one table: slots 0..31 hold super pages for port 0, slots 32..63 hold super pages for port 1, and slots from 64 upward hold the 32-bit window's pages. The 40-bit regular window has a table of its own. Software loads the tables, the two per-port direct bases and the 32-bit page size through a single write port.

Top module: `dma_window_xlate`

## Requirements
- R1: Every request cycle (`req_valid`=1) produces exactly one response cycle (`rsp_valid`=1) on the next clock edge. A cycle without a request produces `rsp_valid`=0 on the next edge.
- R2: An address with bit 63 set returns bits 53:0 zero-extended, with the barrier flag taken from bit 62. It is an error if bit 61 is set or any of bits 60:54 is set.
- R3: Addresses 0x8000_0000..0xFFFF_FFFF return {base[port][63:30], addr[29:0]}, with the barrier flag taken from bit 30. The base is written with `wr_sel`=0, where `wr_idx[0]` selects the port and `wr_data[63:30]` is stored.
- R4: Addresses 0x0..0x7FFF_FFFF take bit 30 as the barrier flag and use bits 29:0 as the window offset. The index is offset >> page_shift and selects shared slot 64+index. An index of 64 or more (SHARED_N-64) is an error.
- R5: Addresses 0x40_0000_0000..0x7F_FFFF_FFFF select entry addr[37:26] of the 40-bit table, use 64 MB pages and never report a barrier. An index of M40_N or more is an error.
- R6: Addresses 0x80_0000_0000..0xFF_FFFF_FFFF select shared slot addr[38:34] + 32*port, use 16 GB pages and never report a barrier.
- R7: A selected entry whose bit 63 is clear gives an error. Any error response has the address and the barrier flag at zero.
- R8: A table translation returns entry bits 62:0 with the bits below the page size cleared, ORed with the offset inside the page. Bit 63 of the result is zero.
- R9: Addresses in none of the five windows are errors.
- R10: `wr_sel`=1 writes shared slot `wr_idx`, `wr_sel`=2 writes 40-bit entry `wr_idx`, and `wr_sel`=3 sets page_shift to `wr_data[4:0]`. A write affects only requests issued in later cycles.
- R11: After reset all entries are invalid, both bases are zero, page_shift is 18 (256 KB) and the response outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_port | input | 1 | Requesting port, 0 or 1 |
| req_addr | input | 64 | I/O-side address |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Write target: 0 base, 1 shared slot, 2 40-bit entry, 3 page shift |
| wr_idx | input | IDX_W | Slot index, or port number for a base write |
| wr_data | input | 64 | Write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_addr | output | 64 | Translated system address |
| rsp_barrier | output | 1 | Barrier flag of the request |
| rsp_err | output | 1 | Translation failed |

## Verification
All results are due on the clock edge that follows the request cycle, so the bench compares each response with the prediction made for the request driven one cycle earlier. It samples on the falling edge, half a cycle after that edge. The bench model forms its prediction before it applies a write issued in the same cycle, because that write only affects the next request. `rsp_valid` is compared in every cycle, including idle cycles, so a missing or extra response is seen at once.

// File: rtl/dma_window_xlate.sv
`timescale 1ns/1ps
module dma_window_xlate #(
  parameter int SHARED_N   = 128,
  parameter int M40_N      = 64,
  parameter int PSHIFT_RST = 18,
  localparam int SH_W  = $clog2(SHARED_N),
  localparam int M40_W = $clog2(M40_N),
  localparam int IDX_W = (SH_W > M40_W) ? SH_W : M40_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_port,
  input  logic [63:0]      req_addr,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [63:0]      wr_data,
  output logic             rsp_valid,
  output logic [63:0]      rsp_addr,
  output logic             rsp_barrier,
  output logic             rsp_err
);
  localparam int SUPER_N = 64;
  localparam int M32_N   = SHARED_N - SUPER_N;
  localparam logic [63:0] M40_PMASK = 64'h0000_0000_03FF_FFFF;
  localparam logic [63:0] SUP_PMASK = 64'h0000_0003_FFFF_FFFF;
  localparam logic [IDX_W:0] SHARED_LIM = (IDX_W+1)'(SHARED_N);
  localparam logic [IDX_W:0] M40_LIM    = (IDX_W+1)'(M40_N);

  logic [63:0] shared_tbl [SHARED_N];
  logic [63:0] m40_tbl [M40_N];
  logic [33:0] dir_base [2];
  logic [4:0]  pshift;

  wire [63:0] a = req_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SHARED_N; i++) shared_tbl[i] <= '0;
      for (int i = 0; i < M40_N; i++) m40_tbl[i] <= '0;
      dir_base[0] <= '0;
      dir_base[1] <= '0;
      pshift <= 5'(PSHIFT_RST);
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: dir_base[wr_idx[0]] <= wr_data[63:30];
        2'd1: if ({1'b0, wr_idx} < SHARED_LIM) shared_tbl[wr_idx[SH_W-1:0]] <= wr_data;
        2'd2: if ({1'b0, wr_idx} < M40_LIM) m40_tbl[wr_idx[M40_W-1:0]] <= wr_data;
        default: pshift <= wr_data[4:0];
      endcase
    end
  end

  wire hi40_zero = (a[63:40] == 24'd0);
  wire in_d64 = a[63];
  wire in_d32 = (a[63:32] == 32'd0) && a[31];
  wire in_m32 = (a[63:31] == 33'd0);
  wire in_m40 = hi40_zero && (a[39:38] == 2'b01);
  wire in_sup = hi40_zero && a[39];

  wire [63:0] pmask = (64'd1 << pshift) - 64'd1;
  wire [29:0] idx32 = a[29:0] >> pshift;
  wire        m32_ok = idx32 < 30'(M32_N);
  wire        m40_ok = {1'b0, a[37:26]} < 13'(M40_N);

  wire [SH_W-1:0] sh_sel = in_sup ? SH_W'({req_port, a[38:34]})
                                  : SH_W'(SUPER_N) + idx32[SH_W-1:0];
  wire [63:0] sh_ent  = shared_tbl[sh_sel];
  wire [63:0] m40_ent = m40_tbl[a[26+M40_W-1:26]];

  logic [63:0] n_addr;
  logic        n_bar, n_err;

  always_comb begin
    n_addr = '0;
    n_bar  = 1'b0;
    n_err  = 1'b0;
    if (in_d64) begin
      if (a[61] || (a[60:54] != 7'd0)) n_err = 1'b1;
      else begin
        n_addr = {10'd0, a[53:0]};
        n_bar  = a[62];
      end
    end else if (in_d32) begin
      n_addr = {dir_base[req_port], a[29:0]};
      n_bar  = a[30];
    end else if (in_m32) begin
      if (!m32_ok || !sh_ent[63]) n_err = 1'b1;
      else begin
        n_addr = ({1'b0, sh_ent[62:0]} & ~pmask) | ({34'd0, a[29:0]} & pmask);
        n_bar  = a[30];
      end
    end else if (in_m40) begin
      if (!m40_ok || !m40_ent[63]) n_err = 1'b1;
      else n_addr = ({1'b0, m40_ent[62:0]} & ~M40_PMASK) | {38'd0, a[25:0]};
    end else if (in_sup) begin
      if (!sh_ent[63]) n_err = 1'b1;
      else n_addr = ({1'b0, sh_ent[62:0]} & ~SUP_PMASK) | {30'd0, a[33:0]};
    end else begin
      n_err = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_addr    <= '0;
      rsp_barrier <= 1'b0;
      rsp_err     <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_addr    <= req_valid ? n_addr : '0;
      rsp_barrier <= req_valid && n_bar;
      rsp_err     <= req_valid && n_err;
    end
  end

  p_resp_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_d64_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[63] && req_addr[61:54] == 8'd0) |=>
      (!rsp_err && rsp_addr == {10'd0, $past(req_addr[53:0])}
       && rsp_barrier == $past(req_addr[62])));
  p_no_bar40_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[63:40] == 24'd0 && req_addr[39:38] != 2'b00) |=> !rsp_barrier);
  p_err_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_addr == 64'd0 && !rsp_barrier));
  p_hole_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[63:40] == 24'd0 && req_addr[39:38] == 2'b00
     && req_addr[37:32] != 6'd0) |=> rsp_err);
endmodule

// File: tb/dma_window_xlate_tb.sv
`timescale 1ns/1ps
module dma_window_xlate_tb;
  localparam int SHARED_N = 128;
  localparam int M40_N    = 64;
  localparam int M32_N    = SHARED_N - 64;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, req_valid, req_port, wr_en;
  logic [63:0] req_addr, wr_data;
  logic [1:0]  wr_sel;
  logic [6:0]  wr_idx;
  logic        rsp_valid, rsp_barrier, rsp_err;
  logic [63:0] rsp_addr;

  dma_window_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
    .req_addr(req_addr), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_barrier(rsp_barrier), .rsp_err(rsp_err)
  );

  int total = 0;
  int bad = 0;

  logic [63:0] m_sh [SHARED_N];
  logic [63:0] m_m40 [M40_N];
  logic [63:0] m_dir [2];
  int          m_shift;

  logic        p_valid;
  logic [63:0] p_addr;
  logic        p_bar, p_err;
  string       p_tag;

  task automatic predict(input logic port, input logic [63:0] a);
    logic [63:0] off, pg, idx, ent;
    p_addr = '0; p_bar = 1'b0; p_err = 1'b0;
    if (a >= 64'h8000_0000_0000_0000) begin
      p_tag = "R2";
      if (a[61] || a[60:54] != 0) p_err = 1'b1;
      else begin p_addr = a & 64'h003F_FFFF_FFFF_FFFF; p_bar = a[62]; end
    end else if (a >= 64'h8000_0000 && a <= 64'hFFFF_FFFF) begin
      p_tag = "R3";
      p_addr = m_dir[port] | (a & 64'h3FFF_FFFF);
      p_bar = a[30];
    end else if (a <= 64'h7FFF_FFFF) begin
      p_tag = "R4 R8";
      off = a & 64'h3FFF_FFFF;
      pg = 64'd1 << m_shift;
      idx = off / pg;
      if (idx >= 64'(M32_N)) p_err = 1'b1;
      else begin
        ent = m_sh[64 + idx];
        if (!ent[63]) begin p_err = 1'b1; p_tag = "R7"; end
        else begin
          p_addr = (ent & ~(pg - 1) & 64'h7FFF_FFFF_FFFF_FFFF) + (off % pg);
          p_bar = a[30];
        end
      end
    end else if (a >= 64'h40_0000_0000 && a <= 64'h7F_FFFF_FFFF) begin
      p_tag = "R5 R8";
      off = a - 64'h40_0000_0000;
      pg = 64'd1 << 26;
      idx = off / pg;
      if (idx >= 64'(M40_N)) p_err = 1'b1;
      else begin
        ent = m_m40[idx];
        if (!ent[63]) begin p_err = 1'b1; p_tag = "R7"; end
        else p_addr = (ent & ~(pg - 1) & 64'h7FFF_FFFF_FFFF_FFFF) + (off % pg);
      end
    end else if (a >= 64'h80_0000_0000 && a <= 64'hFF_FFFF_FFFF) begin
      p_tag = "R6 R8";
      off = a - 64'h80_0000_0000;
      pg = 64'd1 << 34;
      idx = off / pg + (port ? 64'd32 : 64'd0);
      ent = m_sh[idx];
      if (!ent[63]) begin p_err = 1'b1; p_tag = "R7"; end
      else p_addr = (ent & ~(pg - 1) & 64'h7FFF_FFFF_FFFF_FFFF) + (off % pg);
    end else begin
      p_tag = "R9";
      p_err = 1'b1;
    end
  endtask

  task automatic compare();
    total++;
    if (rsp_valid !== p_valid) begin
      bad++;
      $display("FAIL R1: rsp_valid=%b expected %b", rsp_valid, p_valid);
    end
    if (p_valid) begin
      total++;
      if (rsp_addr !== p_addr || rsp_barrier !== p_bar || rsp_err !== p_err) begin
        bad++;
        $display("FAIL %s: addr=%h bar=%b err=%b expected addr=%h bar=%b err=%b",
                 p_tag, rsp_addr, rsp_barrier, rsp_err, p_addr, p_bar, p_err);
      end
    end
  endtask

  task automatic step(input logic v, input logic port, input logic [63:0] a,
                      input logic we, input logic [1:0] sel, input int idx,
                      input logic [63:0] d);
    @(negedge clk);
    compare();
    req_valid = v; req_port = port; req_addr = a;
    wr_en = we; wr_sel = sel; wr_idx = 7'(idx); wr_data = d;
    p_valid = v;
    if (v) predict(port, a);
    if (we) begin
      case (sel)
        2'd0: m_dir[idx % 2] = d & ~64'h3FFF_FFFF;
        2'd1: if (idx < SHARED_N) m_sh[idx] = d;
        2'd2: if (idx < M40_N) m_m40[idx] = d;
        default: m_shift = int'(d[4:0]);
      endcase
    end
  endtask

  task automatic req(input logic port, input logic [63:0] a);
    step(1'b1, port, a, 1'b0, 2'd0, 0, 64'd0);
  endtask

  task automatic wr(input logic [1:0] sel, input int idx, input logic [63:0] d);
    step(1'b0, 1'b0, 64'd0, 1'b1, sel, idx, d);
  endtask

  localparam logic [63:0] V = 64'h8000_0000_0000_0000;

  initial begin
    #500000;
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_port = 1'b0; req_addr = '0;
    wr_en = 1'b0; wr_sel = '0; wr_idx = '0; wr_data = '0;
    p_valid = 1'b0; p_addr = '0; p_bar = 1'b0; p_err = 1'b0; p_tag = "R11";
    for (int i = 0; i < SHARED_N; i++) m_sh[i] = '0;
    for (int i = 0; i < M40_N; i++) m_m40[i] = '0;
    m_dir[0] = '0; m_dir[1] = '0; m_shift = 18;
    repeat (3) begin
      @(negedge clk);
      total++;
      if (rsp_valid !== 1'b0 || rsp_addr !== 64'd0 || rsp_err !== 1'b0 || rsp_barrier !== 1'b0) begin
        bad++;
        $display("FAIL R11: reset outputs v=%b addr=%h err=%b expected all zero",
                 rsp_valid, rsp_addr, rsp_err);
      end
    end
    rst_n = 1'b1;

    // R11: state after reset
    req(1'b0, 64'h0000_0000);
    req(1'b0, 64'h8000_1234);
    req(1'b1, 64'hC000_0010);
    req(1'b0, 64'h40_0000_0000);
    req(1'b1, 64'h80_0000_0000);

    // R2: 64-bit direct window
    req(1'b0, 64'h8000_0000_0000_1000);
    req(1'b1, 64'hC03F_FFFF_FFFF_FFFF);
    req(1'b0, 64'hA000_0000_0000_0040);
    req(1'b0, 64'h8040_0000_0000_0000);

    // R3: per-port direct bases
    wr(2'd0, 0, 64'h0000_0012_C000_0000);
    wr(2'd0, 1, 64'hABCD_0000_7FFF_FFFF);
    req(1'b0, 64'h8765_4321);
    req(1'b1, 64'hC000_0010);
    req(1'b1, 64'hFFFF_FFFF);

    // R4 R8: 32-bit table window, default 256 KB pages
    wr(2'd1, 64, V | 64'h0000_0001_2340_0000);
    wr(2'd1, 65, V | 64'h0000_00AB_CDEC_0000);
    wr(2'd1, 127, V | 64'h0000_0F00_0004_0000);
    req(1'b0, 64'h0000_0123);
    req(1'b1, 64'h4004_0456);
    req(1'b0, 64'h00FF_FFFF);
    req(1'b0, 64'h0100_0000);
    req(1'b0, 64'h0008_0000);
    // R10: page shift change to 1 MB
    wr(2'd3, 0, 64'd20);
    req(1'b0, 64'h0010_0005);
    req(1'b0, 64'h000F_FFFF);
    req(1'b0, 64'h03F0_0001);
    wr(2'd3, 0, 64'd18);

    // R5: 40-bit regular window
    wr(2'd2, 0, V | 64'h0000_0123_4400_0000);
    wr(2'd2, 63, V | 64'h7000_0000_0C00_0000);
    req(1'b0, 64'h40_0000_0123);
    req(1'b1, 64'h40_FFFF_FFFF);
    req(1'b0, 64'h41_0000_0000);
    req(1'b0, 64'h40_1400_0000);

    // R6: super pages, per-port banks
    wr(2'd1, 3, V | 64'h0000_0040_0000_0000);
    wr(2'd1, 35, V | 64'h0000_0C00_0000_0000);
    wr(2'd1, 63, V | 64'h0000_1000_0000_0000);
    req(1'b0, 64'h8C_0000_0777);
    req(1'b1, 64'h8C_0000_0777);
    req(1'b1, 64'h90_0000_0000);
    req(1'b1, 64'hFF_FFFF_FFFF);
    req(1'b0, 64'hFF_FFFF_FFFF);

    // R9: holes between windows
    req(1'b0, 64'h0000_0001_0000_0000);
    req(1'b0, 64'h0000_0100_0000_0000);
    req(1'b1, 64'h7FFF_FFFF_FFFF_FFFF);

    // R10: write in the same cycle as a request affects only later requests
    step(1'b1, 1'b0, 64'h0000_0123, 1'b1, 2'd1, 64, 64'd0);
    req(1'b0, 64'h0000_0123);
    step(1'b1, 1'b0, 64'h40_0000_0010, 1'b1, 2'd2, 0, V | 64'h0000_0555_0000_0000);
    req(1'b0, 64'h40_0000_0010);

    // R7: invalidated super entry
    wr(2'd1, 35, 64'h0000_0C00_0000_0000);
    req(1'b1, 64'h8C_0000_0001);

    // R1: idle cycles then final compare
    repeat (3) step(1'b0, 1'b0, 64'd0, 1'b0, 2'd0, 0, 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule